// File: doc/BRIEF.md
# Fixed-Width Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of W bits and returns only the upper W bits of the 2W-bit product. It is meant for datapaths that keep a fixed word size, where the low half of every product would be thrown away anyway. The multiplier operand is recoded into W/2 radix-4 signed digits. Each digit selects zero, plus or minus once the multiplicand, or plus or minus twice the multiplicand, for one partial-product row.

The low-order columns of the partial-product array are never summed. Every column below the boundary column W-1 is dropped. In their place, a single estimated carry is injected at the boundary column. The estimate is taken from the recoder flags alone, so no adder logic is spent on columns whose result is discarded.

Sign extension of the rows uses one precomputed constant, together with an inverted sign bit per row. An optional output register, enabled by default, holds the result for one clock.

Top module: `booth_fw_mul`

## Requirements
- R1: Each digit i is recoded from the triplet {Y[2i+1], Y[2i], Y[2i-1]}, where Y[-1] is 0. The code 000 and the code 111 give 0. The codes 001 and 010 give +1, and 011 gives +2. The code 100 gives -2, and the codes 101 and 110 give -1. For every digit, exactly one of the flags "one", "two" and "zero" is set.
- R2: A row for a ±1 digit takes multiplicand bit j at row bit j. A row for a ±2 digit takes multiplicand bit j-1 at row bit j, with 0 shifted in at row bit 0. A digit that is negative and non-zero inverts its whole row and raises a correction flag worth one unit at the row's lowest column. The code 111 raises no correction flag.
- R3: Let M be the total weight of all row bits and correction bits that lie in columns 0 to W-2, and let c be the compensation carry. P equals bits [2W-1:W] of (X·Y − M + c·2^(W-1)) mod 2^(2W).
- R4: The compensation carry c is 1 when two or more digits are non-zero, and 0 otherwise.
- R5: Let E be the exact value floor(X·Y / 2^W) mod 2^W. The difference P − E, read as a signed W-bit value, always lies between −2 and +1.
- R6: With the output register enabled, P reflects the operands present at the preceding rising clock edge. An active-low asynchronous reset forces P to 0 at once.
- R7: When Y is 0, P is 0 for every X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_i | input | W | Multiplicand, signed |
| y_i | input | W | Multiplier, signed; recoded into digits |
| p_o | output | W | Upper W bits of the truncated product |

## Verification
With the default output register, each result is due at the first rising edge after its operands are applied. The bench therefore drives operands on a falling edge and samples P on the following falling edge, half a period clear of the edge that loads the register. One directed case samples P shortly after new operands are driven but before that rising edge, and expects the previous result still to be held. The reset case samples P one nanosecond after reset is asserted in the middle of a cycle.

// File: rtl/booth_fw_pkg.sv
package booth_fw_pkg;

    // Flags produced for one radix-4 digit
    typedef struct packed {
        logic neg;   // sign bit of the recoded triplet
        logic one;   // magnitude 1
        logic two;   // magnitude 2
        logic zero;  // digit is zero
        logic cor;   // negative and non-zero: +1 at row LSB
    } digit_t;

endpackage

// File: rtl/booth_fw_recoder.sv
module booth_fw_recoder
    import booth_fw_pkg::*;
(
    input  logic [2:0] trip_i,
    output digit_t     dig_o
);

    always_comb begin
        dig_o.zero = (trip_i == 3'b000) || (trip_i == 3'b111);
        dig_o.one  = trip_i[1] ^ trip_i[0];
        dig_o.two  = !dig_o.zero && !dig_o.one;
        dig_o.neg  = trip_i[2];
        dig_o.cor  = trip_i[2] && !dig_o.zero;
    end

endmodule

// File: rtl/booth_fw_row.sv
module booth_fw_row #(
    parameter int W   = 8,
    parameter int POS = 0
) (
    input  logic [W-1:0]   x_i,
    input  logic           one_i,
    input  logic           two_i,
    input  logic           inv_i,
    output logic [2*W-1:0] row_o
);

    localparam int PW = 2 * W;

    logic [W:0] xe;
    logic [W:0] xs;
    logic [W:0] bits;

    always_comb begin
        xe   = {x_i[W-1], x_i};
        xs   = {xe[W-1:0], 1'b0};
        bits = (({(W+1){one_i}} & xe) | ({(W+1){two_i}} & xs)) ^ {(W+1){inv_i}};
        row_o            = '0;
        row_o[POS +: W]  = bits[W-1:0];
        row_o[POS + W]   = !bits[W];
    end

endmodule

// File: rtl/booth_fw_comp.sv
module booth_fw_comp #(
    parameter int NDIG = 4
) (
    input  logic [NDIG-1:0] zero_i,
    output logic            carry_o
);

    localparam int CW = $clog2(NDIG + 1);

    logic [CW-1:0] live;

    always_comb begin
        live = '0;
        for (int i = 0; i < NDIG; i++) begin
            live = live + CW'(!zero_i[i]);
        end
        carry_o = (live >= CW'(2));
    end

endmodule

// File: rtl/booth_fw_mul.sv
module booth_fw_mul
    import booth_fw_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] p_o
);

    localparam int NDIG     = W / 2;
    localparam int PW       = 2 * W;
    localparam int KEEP_COL = W - 1;
    localparam logic [PW-1:0] KEEP_MASK = {PW{1'b1}} << KEEP_COL;

    function automatic logic [PW-1:0] sign_const();
        logic [PW-1:0] k;
        k = '0;
        for (int i = 0; i < NDIG; i++) begin
            k = k - (PW'(1) << (2 * i + W));
        end
        return k;
    endfunction

    localparam logic [PW-1:0] SIGN_K = sign_const();

    typedef struct packed {
        logic [W-1:0] prod;
    } state_t;

    logic [W:0]      ypad;
    digit_t          dig   [NDIG];
    logic [PW-1:0]   row_v [NDIG];
    logic [NDIG-1:0] dig_neg, dig_one, dig_two, dig_zero, dig_cor;
    logic            comp_c;
    logic [PW-1:0]   cor_pos;
    logic [PW-1:0]   acc;
    state_t          st_d;

    assign ypad = {y_i, 1'b0};

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        booth_fw_recoder u_rec (
            .trip_i (ypad[2*g+2 -: 3]),
            .dig_o  (dig[g])
        );
        booth_fw_row #(.W(W), .POS(2*g)) u_row (
            .x_i   (x_i),
            .one_i (dig[g].one),
            .two_i (dig[g].two),
            .inv_i (dig[g].cor),
            .row_o (row_v[g])
        );
        assign dig_neg[g]  = dig[g].neg;
        assign dig_one[g]  = dig[g].one;
        assign dig_two[g]  = dig[g].two;
        assign dig_zero[g] = dig[g].zero;
        assign dig_cor[g]  = dig[g].cor;
    end

    booth_fw_comp #(.NDIG(NDIG)) u_comp (
        .zero_i  (dig_zero),
        .carry_o (comp_c)
    );

    // Sum the kept columns only; correction bits sit in dropped columns
    always_comb begin
        cor_pos = '0;
        for (int g = 0; g < NDIG; g++) begin
            cor_pos[2*g] = dig_cor[g];
        end
        acc = SIGN_K;
        for (int g = 0; g < NDIG; g++) begin
            acc = acc + (row_v[g] & KEEP_MASK);
        end
        acc = acc + (cor_pos & KEEP_MASK);
        acc = acc + (PW'(comp_c) << KEEP_COL);
        st_d.prod = acc[PW-1:W];
    end

    if (REG_OUT) begin : g_reg
        state_t st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign p_o = st_q.prod;
    end else begin : g_comb
        assign p_o = st_d.prod;
    end

endmodule

// File: rtl/booth_fw_mul_chk.sv
module booth_fw_mul_chk #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     y_i,
    input logic [W-1:0]     p_o,
    input logic [W/2-1:0]   dig_neg,
    input logic [W/2-1:0]   dig_one,
    input logic [W/2-1:0]   dig_two,
    input logic [W/2-1:0]   dig_zero,
    input logic [W/2-1:0]   dig_cor,
    input logic             comp_c
);

    localparam int NDIG = W / 2;

    logic [W:0] ypad;
    assign ypad = {y_i, 1'b0};

    for (genvar g = 0; g < NDIG; g++) begin : g_chk
        // R1: one magnitude class per digit
        a_r1_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot({dig_one[g], dig_two[g], dig_zero[g]}));

        // R2: correction only for negative non-zero triplets
        a_r2_cor_code: assert property (@(posedge clk) disable iff (!rst_n)
            dig_cor[g] |-> (dig_neg[g] && ypad[2*g+2 -: 3] != 3'b111));
    end

    // R4: carry estimate follows the count of live digits
    a_r4_comp_count: assert property (@(posedge clk) disable iff (!rst_n)
        comp_c == ($countones(~dig_zero) >= 2));

    if (REG_OUT) begin : g_reg
        // R7: zero multiplier yields zero one clock later
        a_r7_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
            (y_i == '0) |=> (p_o == '0));
    end else begin : g_comb
        a_r7_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
            (y_i == '0) |-> (p_o == '0));
    end

endmodule

bind booth_fw_mul booth_fw_mul_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .y_i      (y_i),
    .p_o      (p_o),
    .dig_neg  (dig_neg),
    .dig_one  (dig_one),
    .dig_two  (dig_two),
    .dig_zero (dig_zero),
    .dig_cor  (dig_cor),
    .comp_c   (comp_c)
);

// File: tb/sim_booth_fw_mul.sv
`timescale 1ns/1ps
module sim_booth_fw_mul;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] x_i = '0;
    logic [7:0] y_i = '0;
    logic [7:0] p_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = !clk;

    booth_fw_mul #(.W(8), .REG_OUT(1'b1)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (x_i),
        .y_i   (y_i),
        .p_o   (p_o)
    );

    // {x, y, expected p}, hand-worked from the requirements
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h00},  // R7 all digits zero
        {8'h40, 8'h40, 8'h10},  // R1 single +1 digit at top, no minor bits
        {8'h7F, 8'h40, 8'h1F},  // R3 one minor bit dropped
        {8'h80, 8'h80, 8'h3F},  // R2 -2 digit, inverted row, c=0
        {8'h40, 8'h05, 8'h01},  // R4 two live digits, carry injected
        {8'h01, 8'h01, 8'h00},  // R3 product lost in minor part
        {8'hFF, 8'hFF, 8'h00},  // R2 code 111 digits and -1 digit
        {8'h7F, 8'h80, 8'hC0},  // R2 negative result with -2 digit
        {8'hD2, 8'hD3, 8'h07}   // R1 codes 110,001,010,110
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Arithmetic model of R1-R4
    function automatic logic [7:0] ref_p(input logic [7:0] xa, input logic [7:0] ya);
        int xs, ys, yp, m, nz, s;
        xs = int'($signed(xa));
        ys = int'($signed(ya));
        yp = int'({ya, 1'b0});
        m  = 0;
        nz = 0;
        for (int i = 0; i < 4; i++) begin
            int gr, d, mag, r;
            gr  = (yp >> (2 * i)) & 7;
            d   = -2 * ((gr >> 2) & 1) + ((gr >> 1) & 1) + (gr & 1);
            if (d != 0) nz++;
            mag = (d < 0 ? -d : d) * xs;
            r   = (d < 0 ? ~mag : mag) & 511;
            m   = m + ((r << (2 * i)) & 127);
            if (d < 0) m = m + (1 << (2 * i));
        end
        s = xs * ys - m + (nz >= 2 ? 128 : 0);
        return 8'((s & 65535) >> 8);
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int   err_sum;
        int   err_max;
        logic [7:0] prev;

        err_sum = 0;
        err_max = 0;

        // R6: reset state
        #5;
        check("R6 reset value", p_o, 8'h00);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk (drive on falling edge, sample one clock later)
        for (int v = 0; v < NV; v++) begin
            x_i = VEC[v][23:16];
            y_i = VEC[v][15:8];
            @(negedge clk);
            check("R1 R2 R3 R4 R7 table", p_o, VEC[v][7:0]);
        end

        // Exhaustive sweep: exact model and error bound
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                int ex, e;
                x_i = 8'(a);
                y_i = 8'(b);
                @(negedge clk);
                check("R3 R4 sweep", p_o, ref_p(8'(a), 8'(b)));
                ex = ((int'($signed(8'(a))) * int'($signed(8'(b)))) >>> 8) & 255;
                e  = int'(p_o) - ex;
                if (e > 127)  e = e - 256;
                if (e < -128) e = e + 256;
                err_sum = err_sum + e;
                if ((e < 0 ? -e : e) > err_max) err_max = (e < 0 ? -e : e);
                n_chk++;
                if (e < -2 || e > 1) begin
                    n_bad++;
                    $display("FAIL R5 bound x=%02h y=%02h: got %0d expected -2..1", a, b, e);
                end
            end
        end
        $display("error vs exact upper half: mean %f LSB, max |err| %0d LSB",
                 real'(err_sum) / 65536.0, err_max);

        // R6: output holds until the next rising edge
        x_i = 8'h40; y_i = 8'h40;
        @(negedge clk);
        prev = p_o;
        check("R6 settled", prev, 8'h10);
        x_i = 8'h7F; y_i = 8'h80;
        #2;
        check("R6 held before edge", p_o, 8'h10);
        @(negedge clk);
        check("R6 updated after edge", p_o, 8'hC0);

        // R7: zero multiplier with extreme multiplicand
        x_i = 8'h80; y_i = 8'h00;
        @(negedge clk);
        check("R7 zero multiplier", p_o, 8'h00);

        // R6: asynchronous reset mid-cycle
        x_i = 8'hD2; y_i = 8'hD3;
        @(negedge clk);
        check("R1 worked case", p_o, 8'h07);
        #3;
        rst_n = 1'b0;
        #1;
        check("R6 async reset", p_o, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule